// File: doc/BRIEF.md
# Processor Debug Breakpoint Comparator

This block sits beside a small embedded processor and watches its instruction fetch and its data bus. Eight comparators each hold a value, a don't-care mask and an attribute byte: two compare the fetch PC, two the data address, two the read data and two the write data. A comparator's condition fires when four things hold. Its kind of bus activity is present. Its compare is enabled. The active hardware context passes its optional context filter. Its compare succeeds. Every firing condition that is also enabled in the trigger register raises a halt request in the following cycle and sets a sticky bit in the reason register.

The two value comparator pairs (read and write) can replace the masked equality test with an unsigned greater-or-equal test, a lower-or-equal test, or both. Software reaches every register over a simple word-addressed bus with a single-cycle write and a combinational read. Each trigger enable is written as a self-masking two-bit pair, so one bus write can change any subset of conditions and leave the rest alone. The trigger register holds two groups of enables. A condition counts as enabled when either group enables it.

A small hit-log state machine records the first hit. It has two states. `HL_WATCH` means no hit has been logged since reset or since the last clear. `HL_HELD` means at least one hit has been logged and the context of that first hit is frozen. Transitions: WATCH goes to HELD when any enabled condition fires. HELD goes back to WATCH when software writes the reason register in a cycle with no firing condition. HELD stays in HELD in every other case. A clear that coincides with a firing condition stays in HELD and logs the new hit.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, halt_req is 0, hit_reason is 0, and every value, mask, attribute and trigger register reads back 0.
- R2: Word address map. Addresses 0x00–0x0F hold comparator c = addr[3:1] (c = 0 pc0, 1 pc1, 2 da0, 3 da1, 4 rv0, 5 rv1, 6 wv0, 7 wv1), with the value at the even address and the mask at the odd address. 0x10+c holds the 8-bit attribute of comparator c. 0x18 is the trigger register and 0x19 is the reason register. A write takes effect at the clock edge. A read returns the stored value, zero-extended, in the same cycle.
- R3: halt_req is high in the cycle after one or more enabled conditions fire, and low in the cycle after none fire. Several conditions firing together set all their reason bits.
- R4: A PC, data-address or value equality compare ignores every bit position whose mask bit is 1.
- R5: Attribute bit 7 is the compare enable. With it at 0 the comparator never fires.
- R6: When attribute bit 4 is 1, the comparator fires only if attribute bit k is 1 for the active context k (0–3). When bit 4 is 0, the context is ignored.
- R7: On the read-value and write-value comparators, attribute bit 5 selects unsigned masked probe >= value and bit 6 selects masked probe <= value. If either is set, the comparator fires on the OR of the selected tests in place of equality. On PC and data-address comparators bits 5 and 6 have no effect.
- R8: A trigger write handles each pair separately. The pair at bits 2c+1:2c (group 0) or 16+2c+1:16+2c (group 1) set to 11 enables condition c in that group, 10 disables it, and 00 or 01 leaves it unchanged. A read returns group 0 enables in bits 7:0 and group 1 enables in bits 15:8, with bit c for condition c. A condition is active if either group enables it.
- R9: PC conditions need fetch_vld. Data-address conditions need mem_rd or mem_wr. Read-value conditions need mem_rd. Write-value conditions need mem_wr.
- R10: Reason bit c (c = 0..7) is set when condition c fires and stays set until software clears the reason register.
- R11: For value comparator v (0 rv0, 1 rv1, 2 wv0, 3 wv1), when its condition fires, reason bit 8+2v records the lower-or-equal outcome and bit 9+2v records the greater-or-equal outcome. Both bits are sticky.
- R12: Reason bits 17:16 hold the context active at the first hit since reset or the last clear. Later hits do not change them.
- R13: Any write to the reason register clears all reason bits and returns the log to HL_WATCH. If a condition fires in the same cycle, the new hit is logged, with its context, over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Instruction fetch valid this cycle |
| fetch_pc | input | PC_W | Fetch address |
| mem_rd | input | 1 | Data read access this cycle |
| mem_wr | input | 1 | Data write access this cycle |
| mem_addr | input | DADDR_W | Data access address |
| mem_rdata | input | DATA_W | Data returned by a read |
| mem_wdata | input | DATA_W | Data driven by a write |
| cur_ctx | input | 2 | Active hardware context |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Register bus write (1) or read (0) |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| halt_req | output | 1 | Halt request, one cycle after a firing condition |
| hit_reason | output | 18 | Reason register contents |

## Verification
Each probe stimulus is applied on a falling edge and produces its halt request and its reason update at the next rising edge, so the expected result is due one clock after the stimulus. The driver tags each expected item with that due cycle and queues it. The monitor samples just after each rising edge and compares only the items whose due cycle has arrived. Register reads are combinational, so they are checked a moment after the address is driven in the same cycle. Probe inputs return to idle the cycle after each stimulus, so no stale access can leak into the next check.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int NUM_CMP   = 8;
    localparam int VAL_BASE  = 4;
    localparam int NUM_VAL   = NUM_CMP - VAL_BASE;
    localparam int ATTR_W    = 8;
    localparam int CTX_W     = 2;
    localparam int REG_W     = 32;
    localparam int REG_AW    = 5;
    localparam int GRP_CNT   = 2;
    localparam int GRP_STEP  = 16;
    localparam int RSN_W     = NUM_CMP + 2 * NUM_VAL + CTX_W;

    // attribute bit positions
    localparam int AT_CTXF   = 4;
    localparam int AT_GE     = 5;
    localparam int AT_LE     = 6;
    localparam int AT_EN     = 7;

    // register word addresses
    localparam logic [REG_AW-1:0] A_ATTR0 = 5'h10;
    localparam logic [REG_AW-1:0] A_TRIG  = 5'h18;
    localparam logic [REG_AW-1:0] A_RSN   = 5'h19;

    typedef enum logic [1:0] {
        K_PC    = 2'd0,
        K_DADDR = 2'd1,
        K_RDVAL = 2'd2,
        K_WRVAL = 2'd3
    } cmp_kind_e;

    typedef enum logic {
        HL_WATCH = 1'b0,
        HL_HELD  = 1'b1
    } hl_state_e;

    function automatic cmp_kind_e kind_of(input int idx);
        return cmp_kind_e'(idx / 2);
    endfunction

endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit RELATIONAL = 1'b0
) (
    input  logic [DATA_W-1:0] probe,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] mask,
    input  logic [ATTR_W-1:0] attr,
    input  logic [CTX_W-1:0]  ctx,
    output logic              hit,
    output logic              le_flag,
    output logic              ge_flag
);

    logic [DATA_W-1:0] probe_m;
    logic [DATA_W-1:0] value_m;
    logic              eq;
    logic              ctx_ok;
    logic              raw;

    // mask bit 1 = don't care
    assign probe_m = probe & ~mask;
    assign value_m = value & ~mask;
    assign eq      = (probe_m == value_m);
    assign ctx_ok  = !attr[AT_CTXF] || attr[ctx];

    generate
        if (RELATIONAL) begin : g_rel
            logic rel_sel;
            assign le_flag = (probe_m <= value_m);
            assign ge_flag = (probe_m >= value_m);
            assign rel_sel = attr[AT_GE] | attr[AT_LE];
            assign raw     = rel_sel ? ((attr[AT_GE] & ge_flag) | (attr[AT_LE] & le_flag))
                                     : eq;
        end else begin : g_eq
            logic unused_rel_bits;
            assign unused_rel_bits = attr[AT_GE] ^ attr[AT_LE];
            assign le_flag = 1'b0;
            assign ge_flag = 1'b0;
            assign raw     = eq;
        end
    endgenerate

    assign hit = attr[AT_EN] & ctx_ok & raw;

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [REG_AW-1:0]                 bus_addr,
    input  logic [REG_W-1:0]                  bus_wdata,
    output logic [NUM_CMP-1:0][DATA_W-1:0]    cmp_val,
    output logic [NUM_CMP-1:0][DATA_W-1:0]    cmp_msk,
    output logic [NUM_CMP-1:0][ATTR_W-1:0]    cmp_attr,
    output logic [NUM_CMP-1:0]                cond_en,
    output logic                              rsn_clr,
    output logic [REG_W-1:0]                  rd_data
);

    localparam int IDX_W = $clog2(NUM_CMP);

    logic                               wr_hit;
    logic                               wr_trig;
    logic [GRP_CNT-1:0][NUM_CMP-1:0]    trig_q;

    assign wr_hit  = bus_sel & bus_wr;
    assign wr_trig = wr_hit && (bus_addr == A_TRIG);
    assign rsn_clr = wr_hit && (bus_addr == A_RSN);

    generate
        for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp_regs
            logic sel_pair;
            logic sel_attr;
            assign sel_pair = wr_hit && !bus_addr[REG_AW-1]
                              && (bus_addr[IDX_W:1] == IDX_W'(c));
            assign sel_attr = wr_hit && (bus_addr == A_ATTR0 + REG_AW'(c));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cmp_val[c]  <= '0;
                    cmp_msk[c]  <= '0;
                    cmp_attr[c] <= '0;
                end else begin
                    if (sel_pair && !bus_addr[0]) cmp_val[c] <= bus_wdata[DATA_W-1:0];
                    if (sel_pair &&  bus_addr[0]) cmp_msk[c] <= bus_wdata[DATA_W-1:0];
                    if (sel_attr)                 cmp_attr[c] <= bus_wdata[ATTR_W-1:0];
                end
            end

            for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
                logic [1:0] pair;
                assign pair = bus_wdata[GRP_STEP*g + 2*c +: 2];
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        trig_q[g][c] <= 1'b0;
                    else if (wr_trig && pair[1])
                        trig_q[g][c] <= pair[0];
                end
            end

            assign cond_en[c] = |{trig_q[1][c], trig_q[0][c]};
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (!bus_addr[REG_AW-1]) begin
            if (bus_addr[0])
                rd_data = REG_W'(cmp_msk[bus_addr[IDX_W:1]]);
            else
                rd_data = REG_W'(cmp_val[bus_addr[IDX_W:1]]);
        end else if (!bus_addr[IDX_W]) begin
            rd_data = REG_W'(cmp_attr[bus_addr[IDX_W-1:0]]);
        end else if (bus_addr == A_TRIG) begin
            rd_data = REG_W'({trig_q[1], trig_q[0]});
        end
    end

    // R8: a pair whose strobe bit is 0 leaves its enable unchanged
    a_r8_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trig && !bus_wdata[1]) |=> $stable(trig_q[0][0]));

    // R8: pair 11 turns the condition on
    a_r8_pair_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trig && bus_wdata[1:0] == 2'b11) |=> trig_q[0][0]);

    // R8: pair 10 turns the group-1 condition off
    a_r8_pair_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_trig && bus_wdata[GRP_STEP+1:GRP_STEP] == 2'b10) |=> !trig_q[1][0]);

endmodule

// File: rtl/bkpt_hitlog.sv
module bkpt_hitlog
    import bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CMP-1:0]   fire,
    input  logic [NUM_VAL-1:0]   le_in,
    input  logic [NUM_VAL-1:0]   ge_in,
    input  logic [CTX_W-1:0]     ctx,
    input  logic                 clr,
    output logic                 halt_req,
    output logic [RSN_W-1:0]     reason
);

    hl_state_e                state_q;
    hl_state_e                state_d;
    logic                     any_fire;
    logic [NUM_CMP-1:0]       fired_q;
    logic [2*NUM_VAL-1:0]     rel_q;
    logic [2*NUM_VAL-1:0]     rel_new;
    logic [CTX_W-1:0]         ctx_q;
    logic                     capture;

    assign any_fire = |fire;
    assign capture  = any_fire && (state_q == HL_WATCH || clr);

    always_comb begin
        for (int v = 0; v < NUM_VAL; v++) begin
            rel_new[2*v]   = fire[VAL_BASE+v] & le_in[v];
            rel_new[2*v+1] = fire[VAL_BASE+v] & ge_in[v];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HL_WATCH: state_d = any_fire ? HL_HELD : HL_WATCH;
            HL_HELD:  state_d = (clr && !any_fire) ? HL_WATCH : HL_HELD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HL_WATCH;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_req <= 1'b0;
            fired_q  <= '0;
            rel_q    <= '0;
            ctx_q    <= '0;
        end else begin
            halt_req <= any_fire;
            fired_q  <= (clr ? '0 : fired_q) | fire;
            rel_q    <= (clr ? '0 : rel_q) | rel_new;
            if (capture)  ctx_q <= ctx;
            else if (clr) ctx_q <= '0;
        end
    end

    assign reason = {ctx_q, rel_q, fired_q};

    // R3: a halt request always has a logged condition behind it
    a_r3_halt_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (fired_q != '0));

    // R10: without a clear no reason bit drops
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((fired_q & $past(fired_q)) == $past(fired_q)));

    // R12: the captured context holds while held and not cleared
    a_r12_ctx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HL_HELD && !clr) |=> $stable(ctx_q));

    // R13: a clear with no simultaneous hit empties the log
    a_r13_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_fire) |=> (reason == '0 && state_q == HL_WATCH));

    // R12: watching means nothing is logged
    a_r12_watch_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HL_WATCH) |-> (reason == '0));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int DADDR_W = 16,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_vld,
    input  logic [PC_W-1:0]     fetch_pc,
    input  logic                mem_rd,
    input  logic                mem_wr,
    input  logic [DADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [DATA_W-1:0]   mem_wdata,
    input  logic [1:0]          cur_ctx,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                halt_req,
    output logic [17:0]         hit_reason
);

    logic [NUM_CMP-1:0][DATA_W-1:0] cmp_val;
    logic [NUM_CMP-1:0][DATA_W-1:0] cmp_msk;
    logic [NUM_CMP-1:0][ATTR_W-1:0] cmp_attr;
    logic [NUM_CMP-1:0]             cond_en;
    logic [NUM_CMP-1:0]             hit;
    logic [NUM_CMP-1:0]             fire;
    logic [NUM_CMP-1:0]             le_all;
    logic [NUM_CMP-1:0]             ge_all;
    logic                           rsn_clr;
    logic [REG_W-1:0]               regs_rd;
    logic [RSN_W-1:0]               reason;
    logic                           unused_lo_flags;

    bkpt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmp_val   (cmp_val),
        .cmp_msk   (cmp_msk),
        .cmp_attr  (cmp_attr),
        .cond_en   (cond_en),
        .rsn_clr   (rsn_clr),
        .rd_data   (regs_rd)
    );

    generate
        for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
            localparam cmp_kind_e KIND = kind_of(c);
            logic [DATA_W-1:0] probe;
            logic              qual;

            if (KIND == K_PC) begin : g_pc
                assign probe = DATA_W'(fetch_pc);
                assign qual  = fetch_vld;
            end else if (KIND == K_DADDR) begin : g_da
                assign probe = DATA_W'(mem_addr);
                assign qual  = mem_rd | mem_wr;
            end else if (KIND == K_RDVAL) begin : g_rv
                assign probe = mem_rdata;
                assign qual  = mem_rd;
            end else begin : g_wv
                assign probe = mem_wdata;
                assign qual  = mem_wr;
            end

            bkpt_cmp #(
                .DATA_W     (DATA_W),
                .RELATIONAL (c >= VAL_BASE)
            ) u_cmp (
                .probe   (probe),
                .value   (cmp_val[c]),
                .mask    (cmp_msk[c]),
                .attr    (cmp_attr[c]),
                .ctx     (cur_ctx),
                .hit     (hit[c]),
                .le_flag (le_all[c]),
                .ge_flag (ge_all[c])
            );

            assign fire[c] = cond_en[c] & qual & hit[c];
        end
    endgenerate

    assign unused_lo_flags = ^{le_all[VAL_BASE-1:0], ge_all[VAL_BASE-1:0]};

    bkpt_hitlog u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .le_in    (le_all[NUM_CMP-1:VAL_BASE]),
        .ge_in    (ge_all[NUM_CMP-1:VAL_BASE]),
        .ctx      (cur_ctx),
        .clr      (rsn_clr),
        .halt_req (halt_req),
        .reason   (reason)
    );

    assign hit_reason = reason;
    assign bus_rdata  = (bus_addr == A_RSN) ? REG_W'(reason) : regs_rd;

    // R9: with no bus activity at all no condition can fire
    a_r9_idle_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld && !mem_rd && !mem_wr) |=> !halt_req);

    // R10: a halt request shows up together with a nonzero reason port
    a_r10_reason_port: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> (hit_reason[NUM_CMP-1:0] != '0));

endmodule

// File: tb/bkpt_unit_test.sv
module bkpt_unit_test;

    typedef struct {
        int          due;
        bit          halt;
        logic [17:0] rsn;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] mem_addr = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_wdata = '0;
    logic [1:0]  cur_ctx = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        halt_req;
    logic [17:0] hit_reason;

    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    exp_item_t   sb[$];

    // 10 ns period, time unit taken as 1 ns
    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bkpt_unit uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .cur_ctx(cur_ctx),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .halt_req(halt_req), .hit_reason(hit_reason)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    // driver: applies one probe cycle and queues what is due one clock later
    task automatic step(input bit fv, input logic [15:0] pc, input bit rd, input bit wr,
                        input logic [15:0] a, input logic [31:0] rv, input logic [31:0] wv,
                        input logic [1:0] cx, input bit clr,
                        input bit eh, input logic [17:0] er, input string tag);
        exp_item_t it;
        @(negedge clk);
        fetch_vld = fv; fetch_pc = pc; mem_rd = rd; mem_wr = wr; mem_addr = a;
        mem_rdata = rv; mem_wdata = wv; cur_ctx = cx;
        if (clr) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h19; bus_wdata = '0;
        end
        it.due = cyc + 1; it.halt = eh; it.rsn = er; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        fetch_vld = 1'b0; mem_rd = 1'b0; mem_wr = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic fetch(input logic [15:0] pc, input logic [1:0] cx,
                         input bit eh, input logic [17:0] er, input string tag);
        step(1'b1, pc, 1'b0, 1'b0, '0, '0, '0, cx, 1'b0, eh, er, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_item_t it;
                it = sb.pop_front();
                chk({it.tag, " halt"}, 32'(halt_req), 32'(it.halt));
                chk({it.tag, " reason"}, 32'(hit_reason), 32'(it.rsn));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 halt", 32'(halt_req), 0);
        chk("R1 reason", 32'(hit_reason), 0);
        rd_chk(5'h00, 0, "R1 value");
        rd_chk(5'h10, 0, "R1 attr");
        rd_chk(5'h18, 0, "R1 trigger");

        // pc0 equality, R2 readback, R8 enable
        wr_reg(5'h00, 32'h1234);
        wr_reg(5'h01, 0);
        wr_reg(5'h10, 32'h80);
        wr_reg(5'h18, 32'h3);
        rd_chk(5'h00, 32'h1234, "R2 value");
        rd_chk(5'h10, 32'h80, "R2 attr");
        rd_chk(5'h18, 32'h01, "R8 readback");
        fetch(16'h1234, 2'd2, 1'b1, 18'h20001, "R3 pc hit");
        fetch(16'h1235, 2'd1, 1'b0, 18'h20001, "R10 sticky mismatch");
        // R4 mask
        wr_reg(5'h01, 32'h1);
        rd_chk(5'h01, 32'h1, "R2 mask");
        fetch(16'h1235, 2'd1, 1'b1, 18'h20001, "R4 masked hit R12 ctx kept");
        step(1'b0, 16'h1234, 1'b0, 1'b0, '0, '0, '0, 2'd1, 1'b0, 1'b0, 18'h20001, "R9 no fetch");
        // R13 clear
        wr_reg(5'h19, 0);
        rd_chk(5'h19, 0, "R13 cleared");
        // R8 pair codes
        wr_reg(5'h18, 32'h0);
        rd_chk(5'h18, 32'h01, "R8 pair 00 unchanged");
        wr_reg(5'h18, 32'h2);
        rd_chk(5'h18, 32'h00, "R8 pair 10 off");
        fetch(16'h1234, 2'd1, 1'b0, 18'h0, "R8 disabled");
        wr_reg(5'h18, 32'h30000);
        rd_chk(5'h18, 32'h100, "R8 group1 readback");
        fetch(16'h1234, 2'd3, 1'b1, 18'h30001, "R8 group1 hit");
        // R5 compare enable
        wr_reg(5'h10, 32'h00);
        fetch(16'h1234, 2'd3, 1'b0, 18'h30001, "R5 compare off");
        wr_reg(5'h19, 0);
        // R6 context filter: only context 1 allowed
        wr_reg(5'h10, 32'h92);
        fetch(16'h1234, 2'd2, 1'b0, 18'h0, "R6 context blocked");
        fetch(16'h1234, 2'd1, 1'b1, 18'h10001, "R6 context allowed");
        wr_reg(5'h19, 0);
        wr_reg(5'h18, 32'h20002);

        // rv0 greater-or-equal
        wr_reg(5'h08, 100);
        wr_reg(5'h09, 0);
        wr_reg(5'h14, 32'hA0);
        wr_reg(5'h18, 32'h300);
        rd_chk(5'h18, 32'h10, "R8 rv0 readback");
        step(1'b0, '0, 1'b1, 1'b0, '0, 150, '0, 2'd0, 1'b0, 1'b1, 18'h00210, "R7 R11 rv0 ge hit");
        step(1'b0, '0, 1'b1, 1'b0, '0, 50, '0, 2'd0, 1'b0, 1'b0, 18'h00210, "R7 rv0 below");
        step(1'b0, '0, 1'b0, 1'b1, '0, 150, 150, 2'd0, 1'b0, 1'b0, 18'h00210, "R9 no read");
        wr_reg(5'h19, 0);

        // wv1 lower-or-equal
        wr_reg(5'h0E, 40);
        wr_reg(5'h0F, 0);
        wr_reg(5'h17, 32'hC0);
        wr_reg(5'h18, 32'hC000);
        step(1'b0, '0, 1'b0, 1'b1, '0, '0, 40, 2'd1, 1'b0, 1'b1, 18'h1C080, "R11 wv1 le ge");
        step(1'b0, '0, 1'b0, 1'b1, '0, '0, 41, 2'd1, 1'b0, 1'b0, 18'h1C080, "R7 wv1 above");
        wr_reg(5'h19, 0);

        // R7 relational bits ignored on pc1
        wr_reg(5'h02, 10);
        wr_reg(5'h03, 0);
        wr_reg(5'h11, 32'hA0);
        wr_reg(5'h18, 32'hC);
        fetch(16'd20, 2'd0, 1'b0, 18'h0, "R7 pc ignores ge");
        fetch(16'd10, 2'd3, 1'b1, 18'h30002, "R7 pc equality");
        wr_reg(5'h19, 0);

        // R9 data address on writes, not without access
        wr_reg(5'h18, 32'h8230);
        wr_reg(5'h04, 32'h40);
        wr_reg(5'h05, 0);
        wr_reg(5'h12, 32'h80);
        step(1'b0, '0, 1'b0, 1'b1, 16'h40, '0, '0, 2'd1, 1'b0, 1'b1, 18'h10004, "R9 daddr write");
        step(1'b0, '0, 1'b0, 1'b0, 16'h40, '0, '0, 2'd1, 1'b0, 1'b0, 18'h10004, "R9 daddr idle");
        // R13 clear together with a hit
        step(1'b1, 16'd10, 1'b0, 1'b0, '0, '0, '0, 2'd3, 1'b1, 1'b1, 18'h30002, "R13 clear vs hit");
        // R3 two conditions at once
        step(1'b1, 16'd10, 1'b0, 1'b1, 16'h40, '0, '0, 2'd2, 1'b0, 1'b1, 18'h30006, "R3 two hits");
        wr_reg(5'h19, 0);
        rd_chk(5'h19, 0, "R13 final clear");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule